// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. A free-running oscillator clock is divided down into a count clock. On that count clock the block steps through three phases. First it zeroes the analog loop. Next it integrates the unknown input for a fixed window. Last it discharges the integrator with a reference of the opposite sign, counting until the comparator reports that the integrator has crossed zero. The count accumulated in that last phase is the reading, held as four BCD decades together with a sign flag and an overrange flag.

The analog integrator, the comparator and any display decoding sit outside the block. The block drives one switch-select line per phase, and the two discharge lines double as the reference polarity select. It samples a single comparator bit, which is high while the integrator output is above zero. Every measurement takes the same number of count periods whatever the input is, because the zeroing phase absorbs whatever time the discharge phase left unused.

Top module: `dual_slope_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the zeroing phase (`az_o`=1, other phase lines 0), clears `reading_o` to 0 and clears `neg_o` and `ovr_o`.
- R2: One count period is 4 oscillator clocks. The phase lines change only on a count period boundary, and the integrate phase lasts exactly 1000 count periods (4000 clocks).
- R3: At the last count period of integrate, `cmp_i` is sampled. If it is high, discharge runs with `de_pos_o`=1; if it is low, discharge runs with `de_neg_o`=1.
- R4: Discharge stops at the first count period in which `cmp_i` differs from the sampled sign. The reading is the number of discharge count periods before that one, so discharge lasts reading+1 periods.
- R5: If 2000 discharge count periods pass with no crossing, discharge stops, `ovr_o` is set and `reading_o` is 2000. A crossing seen in the 2000th period takes priority, giving 1999 with `ovr_o`=0.
- R6: A full measurement is 4000 count periods. Zeroing follows discharge and lasts 3000 minus the discharge length, and integrate always follows zeroing.
- R7: `reading_o` holds four BCD digits, with digit k (units k=0) at bits 4k+3..4k. The digit value never exceeds 9. The reading changes only when a discharge ends and is held for the whole following measurement.
- R8: `neg_o` is 1 when the sign sampled at the end of integrate was negative (`cmp_i` low). It is updated together with `reading_o`.
- R9: Exactly one of `az_o`, `int_o`, `de_pos_o`, `de_neg_o` is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_i | input | 1 | Comparator: high while integrator output is above zero |
| az_o | output | 1 | Zeroing phase switch select |
| int_o | output | 1 | Signal integrate switch select |
| de_pos_o | output | 1 | Discharge with reference set for a positive input |
| de_neg_o | output | 1 | Discharge with reference set for a negative input |
| reading_o | output | 16 | Latched reading, four BCD digits |
| neg_o | output | 1 | Latched sign, high for negative input |
| ovr_o | output | 1 | Latched overrange flag |

## Verification
The hardest situations to reach from the ports are the edges of the discharge window. One is a crossing that arrives in the very first discharge period, giving a zero reading. Another is a crossing in the 2000th period, which must win over overrange. The third is no crossing at all. The bench models the integrator as a comparator that flips a chosen number of count periods into discharge, timed from the discharge line rising. It drives targets 0, 1, 1999, 2000 and beyond full scale in both signs directly, and also a few seeded random targets.

// File: rtl/dsc_pkg.sv
// Package: shared phase encoding for the dual-slope sequencer.
// Assumes: four phases, decoded one-hot at the top-level outputs.
package dsc_pkg;
    typedef enum logic [1:0] {
        PH_ZERO  = 2'd0,
        PH_INTEG = 2'd1,
        PH_DPOS  = 2'd2,
        PH_DNEG  = 2'd3
    } phase_e;
endpackage

// File: rtl/dsc_prescale.sv
// Module: dsc_prescale
// Divides the oscillator clock and emits a one-clock strobe once per count period.
// Assumes: DIV >= 2; reset restarts the division at zero.
module dsc_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    // Free-running divider counter, wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                      div_q <= '0;
        else if (div_q == DW'(DIV - 1))  div_q <= '0;
        else                             div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == DW'(DIV - 1));

    generate
        if (DIV > 1) begin : g_spacing
            // R2: strobes are never on adjacent clocks.
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dsc_bcd_chain.sv
// Module: dsc_bcd_chain
// Cascaded decimal counter of DIGITS decades, units digit in the low nibble.
// Assumes: clr has priority over inc; the top decade wraps after 9.
module dsc_bcd_chain #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*DIGITS-1:0]   value
);
    logic [DIGITS:0] carry;

    assign carry[0] = inc;

    generate
        for (genvar k = 0; k < DIGITS; k++) begin : g_dec
            logic [3:0] dig_q;

            // One decade: clear, or advance when all lower decades roll over.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)      dig_q <= 4'd0;
                else if (carry[k])      dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
            end

            assign carry[k+1] = carry[k] && (dig_q == 4'd9);
            assign value[4*k +: 4] = dig_q;

            // R7: a decade never holds a non-decimal code.
            assert_digit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
                dig_q <= 4'd9);
        end
    endgenerate
endmodule

// File: rtl/dsc_result_reg.sv
// Module: dsc_result_reg
// Holds the reading, sign and overrange flag between discharge endings.
// Assumes: load is a single-clock strobe at the end of discharge.
module dsc_result_reg #(
    parameter int            BW       = 16,
    parameter logic [BW-1:0] FULL_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] d_value,
    input  logic          d_neg,
    input  logic          d_ovr,
    output logic [BW-1:0] value,
    output logic          neg,
    output logic          ovr
);
    // Capture the result only on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
            neg   <= 1'b0;
            ovr   <= 1'b0;
        end else if (load) begin
            value <= d_value;
            neg   <= d_neg;
            ovr   <= d_ovr;
        end
    end

    // R7: outputs hold unless a discharge just ended.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(value) && $stable(neg) && $stable(ovr)));

    // R5: an overrange result always shows full scale.
    assert_ovr_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> (value == FULL_VAL));
endmodule

// File: rtl/dual_slope_seq.sv
// Module: dual_slope_seq
// Sequences zeroing, fixed integrate and counted discharge of a dual-slope
// converter on a divided count clock, then latches a BCD reading and sign.
// Assumes: cmp_i is synchronous to clk and high while the integrator is above zero.
module dual_slope_seq #(
    parameter int DIV          = 4,
    parameter int DIGITS       = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int FULL_COUNTS  = 2000,
    parameter int CYCLE_COUNTS = 4000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_i,
    output logic                  az_o,
    output logic                  int_o,
    output logic                  de_pos_o,
    output logic                  de_neg_o,
    output logic [4*DIGITS-1:0]   reading_o,
    output logic                  neg_o,
    output logic                  ovr_o
);
    import dsc_pkg::*;

    localparam int BW = 4 * DIGITS;
    localparam int TW = $clog2(CYCLE_COUNTS);

    function automatic logic [BW-1:0] to_bcd(input int unsigned v);
        logic [BW-1:0] r;
        int unsigned   t;
        t = v;
        for (int k = 0; k < DIGITS; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    localparam logic [BW-1:0] LAST_BCD = to_bcd(FULL_COUNTS - 1);
    localparam logic [BW-1:0] FULL_BCD = to_bcd(FULL_COUNTS);

    phase_e         phase_q;
    logic [TW-1:0]  tcnt_q;
    logic           sign_neg_q;
    logic           tick;
    logic [BW-1:0]  count;
    logic           in_de;
    logic           crossing;
    logic           at_last;
    logic           end_de;
    logic           int_done;

    dsc_prescale #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Discharge state and stop conditions.
    assign in_de    = (phase_q == PH_DPOS) || (phase_q == PH_DNEG);
    assign crossing = (phase_q == PH_DPOS) ? !cmp_i : cmp_i;
    assign at_last  = (count == LAST_BCD);
    assign end_de   = tick && in_de && (crossing || at_last);
    assign int_done = tick && (phase_q == PH_INTEG) && (tcnt_q == TW'(INT_COUNTS - 1));

    dsc_bcd_chain #(.DIGITS(DIGITS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (int_done),
        .inc   (tick && in_de),
        .value (count)
    );

    // Cycle position counter and phase transitions, both on count strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_ZERO;
            tcnt_q     <= TW'(INT_COUNTS + FULL_COUNTS);
            sign_neg_q <= 1'b0;
        end else if (tick) begin
            tcnt_q <= (tcnt_q == TW'(CYCLE_COUNTS - 1)) ? '0 : tcnt_q + 1'b1;
            case (phase_q)
                PH_ZERO: if (tcnt_q == TW'(CYCLE_COUNTS - 1)) phase_q <= PH_INTEG;
                PH_INTEG: if (int_done) begin
                    sign_neg_q <= !cmp_i;
                    phase_q    <= cmp_i ? PH_DPOS : PH_DNEG;
                end
                default: if (end_de) phase_q <= PH_ZERO;
            endcase
        end
    end

    dsc_result_reg #(.BW(BW), .FULL_VAL(FULL_BCD)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (end_de),
        .d_value (crossing ? count : FULL_BCD),
        .d_neg   (sign_neg_q),
        .d_ovr   (!crossing),
        .value   (reading_o),
        .neg     (neg_o),
        .ovr     (ovr_o)
    );

    // One-hot phase line decode.
    always_comb begin
        az_o     = (phase_q == PH_ZERO);
        int_o    = (phase_q == PH_INTEG);
        de_pos_o = (phase_q == PH_DPOS);
        de_neg_o = (phase_q == PH_DNEG);
    end

    // R2: phase lines move only on a count strobe from the prescaler.
    assert_phase_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(az_o) && $stable(int_o) && $stable(de_pos_o) && $stable(de_neg_o)));

    // R6: integrate is entered only from zeroing.
    assert_int_after_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |-> $past(az_o));

    // R3: discharge is entered only from integrate.
    assert_de_after_int_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(de_pos_o) || $rose(de_neg_o)) |-> $past(int_o));

    // R5: the discharge count never passes the last full-scale value.
    assert_de_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_de |-> (count <= LAST_BCD));
endmodule

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp = 1'b1;
    logic        az, integ, dpos, dneg, negf, ovrf;
    logic [15:0] reading;

    int checks = 0;
    int errors = 0;
    int tgt = 0;
    bit tgt_neg = 1'b0;
    int de_clk = 0;

    always #10 clk = ~clk;

    dual_slope_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp),
        .az_o(az), .int_o(integ), .de_pos_o(dpos), .de_neg_o(dneg),
        .reading_o(reading), .neg_o(negf), .ovr_o(ovrf)
    );

    // Integrator model: comparator flips once tgt count periods of discharge elapse.
    always @(negedge clk) begin
        if (dpos || dneg) de_clk = de_clk + 1;
        else              de_clk = 0;
        if (de_clk >= 4 * tgt + 1) cmp = tgt_neg;
        else                       cmp = !tgt_neg;
    end

    function automatic logic [15:0] bcd(input int v);
        logic [15:0] r;
        for (int k = 0; k < 4; k++) begin
            r[4*k +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int  nl[9];
        bit  sl[9];
        int  cnt;
        int  de_len;
        bit  hot_bad;
        bit  pol_bad;
        void'($urandom(32'd1234));
        nl = '{0, 1999, 2000, 500, 1, 5000, 0, 0, 0};
        sl = '{0, 0, 0, 1, 1, 1, 0, 0, 0};
        for (int i = 6; i < 9; i++) begin
            nl[i] = int'($urandom % 2000);
            sl[i] = 1'($urandom % 2);
        end

        repeat (5) @(negedge clk);
        // R1: reset state
        chk(az && !integ && !dpos && !dneg, "R1", "phase lines", {az, integ, dpos, dneg}, 8);
        chk(reading == 16'h0 && !negf && !ovrf, "R1", "result", reading, 0);
        rst_n = 1'b1;

        while (!integ) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            int exp_rd;
            tgt = nl[i];
            tgt_neg = sl[i];
            exp_rd = imin(tgt, 2000);
            de_len = imin(tgt + 1, 2000);
            hot_bad = 1'b0;
            pol_bad = 1'b0;
            cnt = 0;
            while (integ) begin
                if ($countones({az, integ, dpos, dneg}) != 1) hot_bad = 1'b1;
                cnt++;
                @(negedge clk);
            end
            chk(cnt == 4000, "R2", "integrate clocks", cnt, 4000);
            chk(dpos == !tgt_neg && dneg == tgt_neg, "R3", "reference select", {dpos, dneg}, {!tgt_neg, tgt_neg});
            cnt = 0;
            while (dpos || dneg) begin
                if ($countones({az, integ, dpos, dneg}) != 1) hot_bad = 1'b1;
                if (dpos != !tgt_neg) pol_bad = 1'b1;
                cnt++;
                @(negedge clk);
            end
            chk(!pol_bad, "R3", "select held", pol_bad, 0);
            chk(cnt == 4 * de_len, "R4", "discharge clocks", cnt, 4 * de_len);
            chk(reading == bcd(exp_rd), "R4", "reading", reading, bcd(exp_rd));
            chk(ovrf == (tgt >= 2000), "R5", "overrange", ovrf, tgt >= 2000);
            chk(negf == tgt_neg, "R8", "sign", negf, tgt_neg);
            cnt = 0;
            while (az) begin
                if ($countones({az, integ, dpos, dneg}) != 1) hot_bad = 1'b1;
                cnt++;
                @(negedge clk);
            end
            chk(cnt == 4 * (3000 - de_len), "R6", "zeroing clocks", cnt, 4 * (3000 - de_len));
            chk(integ, "R6", "integrate follows zeroing", integ, 1);
            chk(reading == bcd(exp_rd) && negf == tgt_neg, "R7", "held through cycle", reading, bcd(exp_rd));
            chk(!hot_bad, "R9", "one-hot phases", hot_bad, 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule